// File: doc/BRIEF.md
# Preemptive Fixed-Priority DMA Channel Arbiter

This block decides which DMA channel a transfer engine serves next. Every channel raises a service request bit. When the engine is idle, the arbiter grants the request with the highest fixed priority. It then holds that grant until the engine reports the end of the transfer. A priority is a group priority followed by a channel priority. The group priority is fixed by the channel's position, and software can set the channel priority.

While a channel runs, the arbiter looks at new requests only as possible preemptions. Both channels must agree before a preemption can happen. The running channel must have its suspendable bit set. The requester must not have its no-preempt bit set. The requester must be strictly higher in priority. Only one suspended channel can be held at a time. When the preempting transfer completes, the suspended channel is resumed before any fresh arbitration. A group of bulk channels can set the no-preempt bit so that they queue behind each other. A truly urgent channel can still interrupt any of them.

The request, status and pulse pins are plain control signals with no valid/ready handshake. The engine acknowledges a grant only through `done_i`, so the arbiter never has to absorb back-pressure.

Top module: `dma_preempt_arb`

## Requirements
- R1: After reset the arbiter is idle (`busy_o`=0, no pulses). Each channel's channel priority is its index modulo 2^CH_PRI_W, and its group priority is its index divided by 2^CH_PRI_W.
- R2: A channel's register reads back combinationally on `reg_rdata_o` for `reg_addr_i`. From MSB to LSB it holds: suspendable bit, no-preempt bit, GRP_W-bit group priority, CH_PRI_W-bit channel priority. A write with `reg_wr_i`=1 updates the suspendable bit, the no-preempt bit and the channel priority on that clock edge.
- R3: Writes leave the group priority field unchanged.
- R4: When idle, the arbiter compares requests on the concatenation {group, channel priority}, and a larger value wins. On a tie, the lower channel index wins. One cycle after the request is sampled, `grant_o` pulses and `grant_ch_o`/`active_ch_o` show the winner.
- R5: A grant is held until `done_i`. After `done_i`, with no suspended channel, `busy_o` drops for one cycle before the next arbitration. `done_i` while idle has no effect.
- R6: A lower or equal priority request that arrives while a channel is active is not granted until that channel is done.
- R7: A request preempts only when four conditions hold. The active channel is not itself a preemptor, the requester is strictly higher in priority, the active channel's suspendable bit is 1, and the requester's no-preempt bit is 0. The highest such requester is chosen, and `grant_o` and `preempt_o` pulse together.
- R8: An active channel whose suspendable bit is 0 is never preempted.
- R9: A channel whose no-preempt bit is 1 never preempts, even when it has higher priority than a suspendable active channel.
- R10: While one channel is suspended, no further preemption occurs.
- R11: On `done_i` of the preempting channel, the suspended channel is resumed on the same edge, ahead of any waiting request, with `grant_o` and `resume_o` pulsing together.
- R12: `grant_o`, `preempt_o` and `resume_o` are one-cycle pulses. `preempt_o` and `resume_o` never coincide, and each occurs only with `grant_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_CH | Per-channel service request |
| reg_wr_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | $clog2(NUM_CH) | Channel selected for write and read |
| reg_wdata_i | input | 2+GRP_W+CH_PRI_W | Write data |
| reg_rdata_o | output | 2+GRP_W+CH_PRI_W | Read data of the selected channel |
| done_i | input | 1 | Active transfer finished |
| busy_o | output | 1 | A channel is being served |
| active_ch_o | output | $clog2(NUM_CH) | Channel being served |
| grant_o | output | 1 | Pulse: a channel was (re)started |
| grant_ch_o | output | $clog2(NUM_CH) | Channel started by the last grant |
| preempt_o | output | 1 | Pulse: the grant suspended the previous channel |
| resume_o | output | 1 | Pulse: the grant resumed the suspended channel |

## Verification
The bench builds the arbiter with NUM_CH=8, CH_PRI_W=2 and GRP_W=2. That gives two groups of four channels and a six-bit register, so group dominance, in-group reordering and ties are all reached with a few writes. It runs a bulk pool with the no-preempt bit set and checks that its members never interrupt each other, while a plain high channel still preempts them. It also holds the single slot occupied while a higher request waits, then checks that the waiting request preempts the resumed channel one cycle later.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_RUN    = 2'd1,
    ARB_NESTED = 2'd2
  } arb_state_e;

endpackage

// File: rtl/dma_pri_regs.sv
module dma_pri_regs #(
  parameter int NUM_CH   = 32,
  parameter int CH_PRI_W = 4,
  parameter int GRP_W    = 2,
  parameter int IDX_W    = $clog2(NUM_CH),
  parameter int KEY_W    = GRP_W + CH_PRI_W,
  parameter int REG_W    = 2 + KEY_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output logic [NUM_CH-1:0]             ecp_vec,
  output logic [NUM_CH-1:0]             dpa_vec,
  output logic [NUM_CH-1:0][KEY_W-1:0]  key_vec
);

  localparam int CH_PER_GRP = 1 << CH_PRI_W;

  logic [NUM_CH-1:0][CH_PRI_W-1:0] chpri_q;
  logic [NUM_CH-1:0][GRP_W-1:0]    grp_c;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int GRP_IDX = g / CH_PER_GRP;
    localparam int PRI_IDX = g % CH_PER_GRP;
    logic sel;

    assign sel        = wr_en && (int'(addr) == g);
    assign grp_c[g]   = GRP_W'(GRP_IDX);
    assign key_vec[g] = {grp_c[g], chpri_q[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ecp_vec[g] <= 1'b0;
        dpa_vec[g] <= 1'b0;
        chpri_q[g] <= CH_PRI_W'(PRI_IDX);
      end else if (sel) begin
        ecp_vec[g] <= wdata[REG_W-1];
        dpa_vec[g] <= wdata[REG_W-2];
        chpri_q[g] <= wdata[CH_PRI_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(addr) == i) rdata = {ecp_vec[i], dpa_vec[i], grp_c[i], chpri_q[i]};
    end
  end

endmodule

// File: rtl/dma_pri_pick.sv
module dma_pri_pick #(
  parameter int NUM_CH = 32,
  parameter int KEY_W  = 6,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]            req,
  input  logic [NUM_CH-1:0][KEY_W-1:0] key_vec,
  output logic                         found,
  output logic [IDX_W-1:0]             win_idx
);

  logic [KEY_W-1:0] best;

  // Strictly-greater replacement keeps the lower index on equal keys.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (!found || key_vec[i] > best)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        best    = key_vec[i];
      end
    end
  end

endmodule

// File: rtl/dma_preempt_arb.sv
module dma_preempt_arb #(
  parameter int NUM_CH   = 32,
  parameter int CH_PRI_W = 4,
  parameter int GRP_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CH-1:0]                  req_i,
  input  logic                               reg_wr_i,
  input  logic [$clog2(NUM_CH)-1:0]          reg_addr_i,
  input  logic [2+GRP_W+CH_PRI_W-1:0]        reg_wdata_i,
  output logic [2+GRP_W+CH_PRI_W-1:0]        reg_rdata_o,
  input  logic                               done_i,
  output logic                               busy_o,
  output logic [$clog2(NUM_CH)-1:0]          active_ch_o,
  output logic                               grant_o,
  output logic [$clog2(NUM_CH)-1:0]          grant_ch_o,
  output logic                               preempt_o,
  output logic                               resume_o
);
  import dma_arb_pkg::*;

  localparam int IDX_W = $clog2(NUM_CH);
  localparam int KEY_W = GRP_W + CH_PRI_W;
  localparam int REG_W = 2 + KEY_W;

  logic [NUM_CH-1:0]            ecp_vec;
  logic [NUM_CH-1:0]            dpa_vec;
  logic [NUM_CH-1:0][KEY_W-1:0] key_vec;
  logic                         all_found, pre_found;
  logic [IDX_W-1:0]             all_idx, pre_idx;
  logic [NUM_CH-1:0]            pre_req;
  logic                         preempt_ok;

  arb_state_e       state_q;
  logic [IDX_W-1:0] act_q, susp_q;

  dma_pri_regs #(
    .NUM_CH(NUM_CH), .CH_PRI_W(CH_PRI_W), .GRP_W(GRP_W),
    .IDX_W(IDX_W), .KEY_W(KEY_W), .REG_W(REG_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i), .rdata(reg_rdata_o),
    .ecp_vec(ecp_vec), .dpa_vec(dpa_vec), .key_vec(key_vec)
  );

  // Idle arbitration sees every request.
  dma_pri_pick #(.NUM_CH(NUM_CH), .KEY_W(KEY_W), .IDX_W(IDX_W)) i_pick_all (
    .req(req_i), .key_vec(key_vec), .found(all_found), .win_idx(all_idx)
  );

  // Preemption candidates exclude channels barred from preempting.
  assign pre_req = req_i & ~dpa_vec;

  dma_pri_pick #(.NUM_CH(NUM_CH), .KEY_W(KEY_W), .IDX_W(IDX_W)) i_pick_pre (
    .req(pre_req), .key_vec(key_vec), .found(pre_found), .win_idx(pre_idx)
  );

  assign preempt_ok = (state_q == ARB_RUN) && !done_i && pre_found &&
                      (key_vec[pre_idx] > key_vec[act_q]) && ecp_vec[act_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      act_q     <= '0;
      susp_q    <= '0;
      grant_o   <= 1'b0;
      preempt_o <= 1'b0;
      resume_o  <= 1'b0;
    end else begin
      grant_o   <= 1'b0;
      preempt_o <= 1'b0;
      resume_o  <= 1'b0;
      case (state_q)
        ARB_IDLE: begin
          if (all_found) begin
            state_q <= ARB_RUN;
            act_q   <= all_idx;
            grant_o <= 1'b1;
          end
        end
        ARB_RUN: begin
          if (done_i) begin
            state_q <= ARB_IDLE;
          end else if (preempt_ok) begin
            state_q   <= ARB_NESTED;
            susp_q    <= act_q;
            act_q     <= pre_idx;
            grant_o   <= 1'b1;
            preempt_o <= 1'b1;
          end
        end
        ARB_NESTED: begin
          if (done_i) begin
            state_q  <= ARB_RUN;
            act_q    <= susp_q;
            grant_o  <= 1'b1;
            resume_o <= 1'b1;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ARB_IDLE);
  assign active_ch_o = act_q;
  assign grant_ch_o  = act_q;

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_i,
  input logic              busy_o,
  input logic [IDX_W-1:0]  active_ch_o,
  input logic              grant_o,
  input logic              preempt_o,
  input logic              resume_o,
  input logic [NUM_CH-1:0] ecp_vec
);

  logic slot_taken_q;
  logic victim_ecp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_taken_q <= 1'b0;
      victim_ecp_q <= 1'b0;
    end else begin
      victim_ecp_q <= ecp_vec[active_ch_o];
      if (preempt_o)     slot_taken_q <= 1'b1;
      else if (resume_o) slot_taken_q <= 1'b0;
    end
  end

  // R10
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |-> !slot_taken_q);

  // R8
  victim_ecp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |-> victim_ecp_q);

  // R11
  resume_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> $past(done_i));

  // R7
  preempt_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |-> $past(busy_o));

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(preempt_o && resume_o));

  // R12
  pulse_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_o || resume_o) |-> grant_o);

  // R12
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |=> !preempt_o);

  // R5
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !grant_o) |-> $stable(active_ch_o));

  // R4
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> busy_o);

endmodule

bind dma_preempt_arb dma_arb_chk #(.NUM_CH(NUM_CH), .IDX_W($clog2(NUM_CH))) i_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .busy_o(busy_o),
  .active_ch_o(active_ch_o), .grant_o(grant_o), .preempt_o(preempt_o),
  .resume_o(resume_o), .ecp_vec(ecp_vec)
);

// File: tb/test_dma_preempt_arb.sv
`timescale 1ns/100ps
module test_dma_preempt_arb;
  localparam int NCH   = 8;
  localparam int PW    = 2;
  localparam int GW    = 2;
  localparam int IW    = $clog2(NCH);
  localparam int RW    = 2 + GW + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] req = '0;
  logic          wr = 1'b0;
  logic [IW-1:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic          done = 1'b0;
  logic          busy, grant, preempt, resume;
  logic [IW-1:0] act_ch, grant_ch;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  logic [IW+1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  dma_preempt_arb #(.NUM_CH(NCH), .CH_PRI_W(PW), .GRP_W(GW)) i_dma_preempt_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .done_i(done), .busy_o(busy),
    .active_ch_o(act_ch), .grant_o(grant), .grant_ch_o(grant_ch),
    .preempt_o(preempt), .resume_o(resume)
  );

  task automatic chk(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic push(string tag, bit p, bit r, int ch);
    exp_q.push_back({p, r, IW'(ch)});
    tag_q.push_back(tag);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Group bits are always driven as ones to exercise the read-only field.
  task automatic set_reg(int ch, bit ecp, bit dpa, int pri);
    @(negedge clk);
    wr = 1'b1; addr = IW'(ch); wdata = {ecp, dpa, {GW{1'b1}}, PW'(pri)};
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, int ch, int expected);
    @(negedge clk);
    addr = IW'(ch);
    #1;
    chk(tag, int'(rdata), expected);
  endtask

  task automatic finish_ch(int ch);
    @(negedge clk);
    done = 1'b1; req[ch] = 1'b0;
    @(negedge clk);
    done = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (grant) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL unexpected grant actual=p%0d r%0d ch%0d expected=none",
                   preempt, resume, grant_ch);
        end else begin
          logic [IW+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e != {preempt, resume, grant_ch}) begin
            bad++;
            $display("FAIL %s actual=p%0d r%0d ch%0d expected=p%0d r%0d ch%0d",
                     t, preempt, resume, grant_ch, e[IW+1], e[IW], e[IW-1:0]);
          end
        end
      end else if (preempt || resume) begin
        total++;
        bad++;
        $display("FAIL R12 pulse without grant actual=p%0d r%0d expected=0", preempt, resume);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state and reset priorities
    chk("R1 busy", busy, 0);
    chk("R1 grant", grant, 0);
    chk("R1 pulses", preempt | resume, 0);
    rd_chk("R1 ch0", 0, 0);
    rd_chk("R1 ch5", 5, 6'b000101);
    rd_chk("R1 ch7", 7, 6'b000111);

    // R2 / R3 register write and read-only group
    set_reg(5, 1, 1, 2);
    rd_chk("R2 write ch5", 5, 6'b110110);
    rd_chk("R3 group kept", 5, 6'b110110);
    set_reg(5, 0, 0, 1);
    rd_chk("R2 restore ch5", 5, 6'b000101);

    // R5 done while idle has no effect
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    cyc(2);
    chk("R5 idle done", busy, 0);

    // R4 / R6 basic arbitration
    push("R4 grant ch6", 0, 0, 6);
    push("R6 ch2 after", 0, 0, 2);
    @(negedge clk); req = 8'b0100_0100;
    cyc(3);
    chk("R6 active holds", act_ch, 6);
    chk("R5 busy", busy, 1);
    finish_ch(6);
    chk("R5 idle gap", busy, 0);
    cyc(2);
    chk("R4 next", act_ch, 2);
    finish_ch(2);
    cyc(2);

    // R4 group dominates, channel priority reorders
    set_reg(1, 0, 0, 3);
    set_reg(3, 0, 0, 0);
    push("R4 group win ch4", 0, 0, 4);
    push("R4 chpri ch1", 0, 0, 1);
    push("R4 last ch3", 0, 0, 3);
    @(negedge clk); req = 8'b0001_1010;
    cyc(2);
    chk("R4 group", act_ch, 4);
    finish_ch(4); cyc(2);
    chk("R4 chpri", act_ch, 1);
    finish_ch(1); cyc(2);
    finish_ch(3); cyc(2);

    // R4 tie: lower index wins
    set_reg(2, 0, 0, 3);
    push("R4 tie ch1", 0, 0, 1);
    push("R4 tie ch2", 0, 0, 2);
    @(negedge clk); req = 8'b0000_0110;
    cyc(2);
    chk("R4 tie", act_ch, 1);
    finish_ch(1); cyc(2);
    finish_ch(2); cyc(2);
    set_reg(1, 0, 0, 1);
    set_reg(2, 0, 0, 2);
    set_reg(3, 0, 0, 3);

    // R7 / R11 plain preemption and resume
    set_reg(2, 1, 0, 2);
    push("R4 grant ch2", 0, 0, 2);
    @(negedge clk); req[2] = 1'b1;
    cyc(2);
    push("R7 preempt ch6", 1, 0, 6);
    @(negedge clk); req[6] = 1'b1;
    cyc(2);
    chk("R7 active", act_ch, 6);
    push("R11 resume ch2", 0, 1, 2);
    finish_ch(6);
    chk("R11 resumed", act_ch, 2);
    finish_ch(2); cyc(2);

    // R8 victim not suspendable
    set_reg(2, 0, 0, 2);
    push("R8 grant ch2", 0, 0, 2);
    @(negedge clk); req[2] = 1'b1;
    cyc(2);
    @(negedge clk); req[6] = 1'b1;
    cyc(4);
    chk("R8 no preempt", act_ch, 2);
    push("R8 ch6 later", 0, 0, 6);
    finish_ch(2); cyc(2);
    chk("R8 ch6", act_ch, 6);
    finish_ch(6); cyc(2);

    // R9 pool of no-preempt channels
    set_reg(1, 1, 1, 1);
    set_reg(2, 1, 1, 2);
    set_reg(3, 1, 1, 3);
    push("R9 grant ch1", 0, 0, 1);
    @(negedge clk); req[1] = 1'b1;
    cyc(2);
    @(negedge clk); req[2] = 1'b1; req[3] = 1'b1;
    cyc(4);
    chk("R9 pool no preempt", act_ch, 1);
    push("R9 ch7 preempts pool", 1, 0, 7);
    @(negedge clk); req[7] = 1'b1;
    cyc(2);
    chk("R9 ch7 active", act_ch, 7);
    push("R11 resume ch1", 0, 1, 1);
    finish_ch(7);
    push("R9 ch3 after", 0, 0, 3);
    finish_ch(1); cyc(2);
    chk("R9 ch3", act_ch, 3);
    push("R9 ch2 after", 0, 0, 2);
    finish_ch(3); cyc(2);
    finish_ch(2); cyc(2);
    set_reg(1, 0, 0, 1);
    set_reg(2, 0, 0, 2);
    set_reg(3, 0, 0, 3);

    // R10 / R11 single slot, resume ahead of waiting request
    set_reg(2, 1, 0, 2);
    set_reg(5, 1, 0, 1);
    push("R10 grant ch2", 0, 0, 2);
    @(negedge clk); req[2] = 1'b1;
    cyc(2);
    push("R7 preempt ch5", 1, 0, 5);
    @(negedge clk); req[5] = 1'b1;
    cyc(2);
    chk("R7 ch5", act_ch, 5);
    @(negedge clk); req[7] = 1'b1;
    cyc(4);
    chk("R10 slot full", act_ch, 5);
    push("R11 resume ch2 first", 0, 1, 2);
    push("R10 ch7 after slot frees", 1, 0, 7);
    finish_ch(5);
    chk("R11 ahead of ch7", act_ch, 2);
    cyc(2);
    chk("R10 ch7 active", act_ch, 7);
    push("R11 resume ch2 again", 0, 1, 2);
    finish_ch(7);
    finish_ch(2);
    cyc(3);
    chk("R5 final idle", busy, 0);
    chk("R12 all events seen", exp_q.size(), 0);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule